// File: doc/BRIEF.md
# DAC Data Source Test-Pattern Mux

This block picks, on every sample clock, the words handed to two 16-bit DAC channels. In normal use each channel takes its own parallel data bus. For bring-up and test, a configuration byte can replace that data in two ways. The first is a fixed 16-bit word held in two register bytes, which goes to both channels. The second is a free-running cyclic counter that drives a chosen bit field of both DAC words. The configuration byte can also complement channel B, which moves the output to the upper sideband.

The block sits just in front of the DAC cores. Both output words are registered, so each output has exactly one cycle of latency from its inputs. The configuration byte and the fixed-word bytes come straight from a register file outside this block. The counter advances on every clock whether or not it is selected, so the pattern it produces depends only on how many cycles have passed since reset.

Top module: `dac_src_mux`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, that edge sets both outputs and the internal counter to zero. The first edge after reset is released uses counter value 0, and the counter value used then rises by one on each later edge.
- R2: When `cfg[4]` is 0, `cfg[0]` is 0 and `cfg[1]` is 0, `dac_a` and `dac_b` equal `bus_a` and `bus_b` as sampled at the previous rising edge.
- R3: With `cfg[4:2]`=100, both outputs carry all 16 counter bits. The counter wraps from 0xFFFF to 0x0000.
- R4: With `cfg[4:2]`=101, output bits 6:0 carry counter bits 6:0 and bits 15:7 are zero.
- R5: With `cfg[4:2]`=110, output bits 10:6 carry counter bits 10:6 and all other bits are zero.
- R6: With `cfg[4:2]`=111, output bits 15:11 carry counter bits 15:11 and bits 10:0 are zero.
- R7: When `cfg[4]` is 0 and `cfg[0]` is 1, both channels output `{fixed_hi, fixed_lo}` and the buses are ignored.
- R8: A counter mode (`cfg[4]`=1) takes priority over the fixed-word override.
- R9: When `cfg[1]` is 1, `dac_b` is the bitwise complement of the word it would otherwise carry, whichever source is selected. `dac_a` is not affected.
- R10: `cfg[7:5]` have no effect on either output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_a | input | 16 | Channel A input data |
| bus_b | input | 16 | Channel B input data |
| cfg | input | 8 | Config: bit0 fixed-word enable, bit1 invert B, bits 4:2 counter mode |
| fixed_lo | input | 8 | Low byte of the fixed word |
| fixed_hi | input | 8 | High byte of the fixed word |
| dac_a | output | 16 | Registered channel A DAC word |
| dac_b | output | 16 | Registered channel B DAC word |

## Verification
The hardest case to reach from the ports is the counter wrap. The counter only rolls over after 65536 cycles from reset, and no input can preload it. The stimulus resets the block, holds the full-width counter mode for exactly one wrap period and checks that the output comes back to zero. Around that, seeded random configurations, bus words and fixed bytes are mixed in to cover every combination of priority and inversion. A bench model keeps its own count of cycles since reset.

// File: rtl/dac_src_pkg.sv
// Package: shared encodings for the DAC data-source mux.
// Assumes: counter mode is a 3-bit field whose top bit enables the counter.
package dac_src_pkg;

    typedef enum logic [2:0] {
        CM_OFF0 = 3'b000,
        CM_OFF1 = 3'b001,
        CM_OFF2 = 3'b010,
        CM_OFF3 = 3'b011,
        CM_FULL = 3'b100,
        CM_LOW  = 3'b101,
        CM_MID  = 3'b110,
        CM_TOP  = 3'b111
    } cnt_mode_e;

    // Positions of fields inside the configuration byte
    localparam int unsigned CFG_FIX_BIT  = 0;
    localparam int unsigned CFG_INV_BIT  = 1;
    localparam int unsigned CFG_MODE_LSB = 2;

endpackage

// File: rtl/dac_pattern_ctr.sv
// Module: free-running cyclic counter used as a test source.
// Assumes: it counts every cycle and wraps at its width; synchronous active-low reset.
module dac_pattern_ctr #(
    parameter int unsigned DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [DW-1:0] count
);

    // Advance by one every cycle, clear on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/dac_field_mask.sv
// Module: turns the counter mode into a bit mask of counter-driven positions.
// Assumes: low field starts at bit 0, top field ends at the MSB, and the middle
// field sits at MID_LSB; the fields lie inside DW.
module dac_field_mask
    import dac_src_pkg::*;
#(
    parameter int unsigned DW      = 16,
    parameter int unsigned LOW_W   = 7,
    parameter int unsigned MID_LSB = 6,
    parameter int unsigned MID_W   = 5,
    parameter int unsigned TOP_W   = 5
) (
    input  logic [2:0]    mode,
    output logic [DW-1:0] mask,
    output logic          active
);

    localparam int unsigned MID_MSB = MID_LSB + MID_W - 1;
    localparam int unsigned TOP_LSB = DW - TOP_W;

    logic [DW-1:0] low_m, mid_m, top_m;

    // Build one mask per field, bit by bit
    for (genvar i = 0; i < DW; i++) begin : g_bit
        assign low_m[i] = (i < LOW_W);
        assign mid_m[i] = (i >= MID_LSB) && (i <= MID_MSB);
        assign top_m[i] = (i >= TOP_LSB);
    end

    // Select the mask for the current mode
    always_comb begin
        active = mode[2];
        unique case (cnt_mode_e'(mode))
            CM_FULL: mask = '1;
            CM_LOW:  mask = low_m;
            CM_MID:  mask = mid_m;
            CM_TOP:  mask = top_m;
            default: mask = '0;
        endcase
    end

endmodule

// File: rtl/dac_src_select.sv
// Module: source priority and channel-B inversion (combinational).
// Assumes: priority is counter, then fixed word, then bus; inversion applied last.
module dac_src_select #(
    parameter int unsigned DW = 16
) (
    input  logic          cnt_on,
    input  logic [DW-1:0] cnt_mask,
    input  logic [DW-1:0] count,
    input  logic          fix_on,
    input  logic [DW-1:0] fix_word,
    input  logic          inv_b,
    input  logic [DW-1:0] bus_a,
    input  logic [DW-1:0] bus_b,
    output logic [DW-1:0] nxt_a,
    output logic [DW-1:0] nxt_b
);

    logic [DW-1:0] pre_b;

    // Choose the word for each channel by priority
    always_comb begin
        if (cnt_on) begin
            nxt_a = count & cnt_mask;
            pre_b = count & cnt_mask;
        end else if (fix_on) begin
            nxt_a = fix_word;
            pre_b = fix_word;
        end else begin
            nxt_a = bus_a;
            pre_b = bus_b;
        end
        nxt_b = inv_b ? ~pre_b : pre_b;
    end

endmodule

// File: rtl/dac_src_mux.sv
// Module: top of the DAC data-source mux; registers both channel words.
// Assumes: cfg and fixed bytes are stable register outputs; synchronous active-low reset.
module dac_src_mux
    import dac_src_pkg::*;
#(
    parameter int unsigned DW      = 16,
    parameter int unsigned BW      = 8,
    parameter int unsigned LOW_W   = 7,
    parameter int unsigned MID_LSB = 6,
    parameter int unsigned MID_W   = 5,
    parameter int unsigned TOP_W   = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] bus_a,
    input  logic [DW-1:0] bus_b,
    input  logic [7:0]    cfg,
    input  logic [BW-1:0] fixed_lo,
    input  logic [BW-1:0] fixed_hi,
    output logic [DW-1:0] dac_a,
    output logic [DW-1:0] dac_b
);

    localparam int unsigned FW = 2 * BW;

    logic [DW-1:0] count;
    logic [DW-1:0] cnt_mask;
    logic          cnt_on;
    logic [FW-1:0] fix_word;
    logic [DW-1:0] nxt_a, nxt_b;

    assign fix_word = {fixed_hi, fixed_lo};

    dac_pattern_ctr #(.DW(DW)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .count (count)
    );

    dac_field_mask #(
        .DW(DW), .LOW_W(LOW_W), .MID_LSB(MID_LSB), .MID_W(MID_W), .TOP_W(TOP_W)
    ) u_mask (
        .mode   (cfg[CFG_MODE_LSB +: 3]),
        .mask   (cnt_mask),
        .active (cnt_on)
    );

    dac_src_select #(.DW(DW)) u_sel (
        .cnt_on   (cnt_on),
        .cnt_mask (cnt_mask),
        .count    (count),
        .fix_on   (cfg[CFG_FIX_BIT]),
        .fix_word (fix_word[DW-1:0]),
        .inv_b    (cfg[CFG_INV_BIT]),
        .bus_a    (bus_a),
        .bus_b    (bus_b),
        .nxt_a    (nxt_a),
        .nxt_b    (nxt_b)
    );

    // Output register: one cycle of latency for both channels
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dac_a <= '0;
            dac_b <= '0;
        end else begin
            dac_a <= nxt_a;
            dac_b <= nxt_b;
        end
    end

endmodule

// File: rtl/dac_src_mux_chk.sv
// Module: assertion checker for dac_src_mux, attached with bind below.
// Assumes: default field layout (low 7, middle 10:6, top 15:11) of a 16-bit word.
module dac_src_mux_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] bus_a,
    input logic [15:0] bus_b,
    input logic [7:0]  cfg,
    input logic [7:0]  fixed_lo,
    input logic [7:0]  fixed_hi,
    input logic [15:0] dac_a,
    input logic [15:0] dac_b
);

    // R1: a reset edge leaves both outputs at zero
    p_reset_zero_r1: assert property (@(posedge clk)
        !rst_n |=> (dac_a == 16'h0 && dac_b == 16'h0));

    // R2: plain pass-through with one cycle of latency
    p_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cfg[4:0]) == 5'b00000)
        |-> (dac_a == $past(bus_a) && dac_b == $past(bus_b)));

    // R3: full-width counter steps by one between consecutive cycles
    p_full_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2) && $past(cfg[4:2]) == 3'b100
         && $past(cfg[4:2], 2) == 3'b100)
        |-> (dac_a == $past(dac_a) + 16'd1));

    // R4: low field leaves upper bits zero
    p_low_field_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cfg[4:2]) == 3'b101) |-> (dac_a[15:7] == 9'h0));

    // R5: middle field leaves other bits zero
    p_mid_field_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cfg[4:2]) == 3'b110)
        |-> (dac_a[15:11] == 5'h0 && dac_a[5:0] == 6'h0));

    // R6: top field leaves lower bits zero
    p_top_field_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cfg[4:2]) == 3'b111) |-> (dac_a[10:0] == 11'h0));

    // R7: fixed word on channel A when no counter mode
    p_fixed_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(cfg[4]) && $past(cfg[0]))
        |-> (dac_a == {$past(fixed_hi), $past(fixed_lo)}));

    // R9: channel B is the complement of channel A whenever both share a source
    p_invert_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(cfg[4]) || $past(cfg[0])) && $past(cfg[1]))
        |-> (dac_b == ~dac_a));

endmodule

bind dac_src_mux dac_src_mux_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_a    (bus_a),
    .bus_b    (bus_b),
    .cfg      (cfg),
    .fixed_lo (fixed_lo),
    .fixed_hi (fixed_hi),
    .dac_a    (dac_a),
    .dac_b    (dac_b)
);

// File: tb/sim_dac_src_mux.sv
// Bench: seeded random plus directed cases, checked against a bench model.
module sim_dac_src_mux;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_a = '0, bus_b = '0;
    logic [7:0]  cfg = '0, fixed_lo = '0, fixed_hi = '0;
    logic [15:0] dac_a, dac_b;

    int unsigned n_chk = 0;
    int unsigned n_bad = 0;
    logic [15:0] cnt_m = '0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    dac_src_mux u0 (
        .clk(clk), .rst_n(rst_n), .bus_a(bus_a), .bus_b(bus_b), .cfg(cfg),
        .fixed_lo(fixed_lo), .fixed_hi(fixed_hi), .dac_a(dac_a), .dac_b(dac_b)
    );

    // Expected {a, b} from the requirements
    function automatic logic [31:0] model(input logic [7:0] c, input logic [15:0] a,
            input logic [15:0] b, input logic [7:0] lo, input logic [7:0] hi,
            input logic [15:0] n);
        logic [15:0] m, ea, eb;
        case (c[4:2])
            3'b100:  m = 16'hFFFF;
            3'b101:  m = 16'h007F;
            3'b110:  m = 16'h07C0;
            3'b111:  m = 16'hF800;
            default: m = 16'h0000;
        endcase
        if (c[4]) begin
            ea = n & m; eb = n & m;
        end else if (c[0]) begin
            ea = {hi, lo}; eb = {hi, lo};
        end else begin
            ea = a; eb = b;
        end
        if (c[1]) eb = ~eb;
        return {ea, eb};
    endfunction

    function automatic string req_of(input logic [7:0] c);
        if (c[4]) begin
            case (c[3:2])
                2'b00:   return c[0] ? "R8" : (c[1] ? "R9" : "R3");
                2'b01:   return "R4";
                2'b10:   return "R5";
                default: return "R6";
            endcase
        end
        if (c[1]) return "R9";
        if (c[0]) return "R7";
        return "R2";
    endfunction

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp,
            input string ch);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s dac_%s actual=%h expected=%h", tag, ch, got, exp);
        end
    endtask

    // Apply inputs at a falling edge, compare one cycle later
    task automatic step(input logic [7:0] c, input logic [15:0] a, input logic [15:0] b,
            input logic [7:0] lo, input logic [7:0] hi, input string tag);
        logic [31:0] e;
        cfg = c; bus_a = a; bus_b = b; fixed_lo = lo; fixed_hi = hi;
        e = model(c, a, b, lo, hi, cnt_m);
        @(negedge clk);
        check(tag, dac_a, e[31:16], "a");
        check(tag, dac_b, e[15:0], "b");
        cnt_m++;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        cfg = 8'h10; bus_a = 16'hDEAD; bus_b = 16'hBEEF;
        @(negedge clk);
        @(negedge clk);
        check("R1", dac_a, 16'h0, "a");
        check("R1", dac_b, 16'h0, "b");
        rst_n = 1'b1;
        cnt_m = '0;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        do_reset();
        // R1: counter starts at 0 after reset
        step(8'b000_100_00, 16'h1111, 16'h2222, 8'h00, 8'h00, "R1");
        // R2: pass-through patterns
        step(8'h00, 16'h0000, 16'hFFFF, 8'h55, 8'hAA, "R2");
        step(8'h00, 16'hA5A5, 16'h5A5A, 8'h12, 8'h34, "R2");
        step(8'h00, 16'h8001, 16'h7FFE, 8'h00, 8'h00, "R2");
        // R3: full counter
        for (int i = 0; i < 4; i++) step(8'b000_100_00, 16'hFFFF, 16'hFFFF, 8'h0, 8'h0, "R3");
        // R4, R5, R6: field modes
        for (int i = 0; i < 3; i++) step(8'b000_101_00, 16'hFFFF, 16'h0, 8'h0, 8'h0, "R4");
        for (int i = 0; i < 3; i++) step(8'b000_110_00, 16'hFFFF, 16'h0, 8'h0, 8'h0, "R5");
        for (int i = 0; i < 3; i++) step(8'b000_111_00, 16'hFFFF, 16'h0, 8'h0, 8'h0, "R6");
        // R7: fixed word
        step(8'b000_000_01, 16'h1234, 16'h5678, 8'hCD, 8'hAB, "R7");
        step(8'b000_011_01, 16'h1234, 16'h5678, 8'h01, 8'h80, "R7");
        // R8: counter wins over fixed
        step(8'b000_100_01, 16'h1234, 16'h5678, 8'hCD, 8'hAB, "R8");
        step(8'b000_111_01, 16'h1234, 16'h5678, 8'hCD, 8'hAB, "R8");
        // R9: inversion on each source
        step(8'b000_000_10, 16'h00FF, 16'h0F0F, 8'h0, 8'h0, "R9");
        step(8'b000_000_11, 16'h00FF, 16'h0F0F, 8'h34, 8'h12, "R9");
        step(8'b000_101_10, 16'h00FF, 16'h0F0F, 8'h0, 8'h0, "R9");
        // R10: upper config bits ignored
        step(8'b111_000_00, 16'hCAFE, 16'hF00D, 8'h0, 8'h0, "R10");
        step(8'b101_100_10, 16'hCAFE, 16'hF00D, 8'h0, 8'h0, "R10");
        step(8'b010_000_01, 16'hCAFE, 16'hF00D, 8'h77, 8'h66, "R10");
        // Random mix
        for (int i = 0; i < 3000; i++) begin
            logic [7:0] c;
            c = 8'($urandom);
            step(c, 16'($urandom), 16'($urandom), 8'($urandom), 8'($urandom), req_of(c));
        end
        // R3: wrap after a full period from reset
        do_reset();
        for (int i = 0; i < 65536; i++)
            step(8'b000_100_00, 16'h0, 16'h0, 8'h0, 8'h0, "R3");
        step(8'b000_100_00, 16'h0, 16'h0, 8'h0, 8'h0, "R3");
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule